// File: doc/BRIEF.md
# Selectable-Mapping Read Cache Controller

This block is a small read-only cache that sits in front of a 256-byte, byte-addressed backing store. The store lives inside the block as a register array. A dedicated write port fills it before reads begin. The cache has four lines of eight bytes each. A two-bit mode input arranges those lines in one of three ways: direct mapped, fully associative, or two-way set associative. The client issues one byte read at a time over a valid/ready handshake, and each read returns one response that carries a hit flag and the byte.

The controller is built around two states. In `S_IDLE` the controller is ready and looks the address up combinationally. A hit is answered on the accepting edge, and the transition is IDLE→IDLE. A miss takes the transition IDLE→FILL. In `S_FILL` the block is copied one byte per cycle into the victim line. When the last byte arrives, the line is installed and the response is issued, taking the transition FILL→IDLE. A flush, or a change of the mode input, takes the abort transition FILL→IDLE if a fill is in progress. Either event clears the line valid bits, the replacement pointers and the statistics.

Three statistics run alongside the reads: an access count, a hit count, and a time total. The time total adds a fixed lookup cost on every access and a memory cost on every miss, so it models lookup and memory access happening one after the other.

Top module: `tricache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, all three statistics are 0 and every line is invalid, so the first read of any address misses.
- R2: Mode encoding is 0 = direct mapped, 1 = fully associative, 2 = two-way. In mode 0 a block may only reside in line `addr[4:3]` and hits only when its stored `addr[7:5]` matches.
- R3: In mode 1 a block may reside in any line. A miss fills the lowest-numbered invalid line. Once all four lines are valid, a miss evicts lines in the order they were filled (first in, first out), whatever the recent hits.
- R4: In mode 2 `addr[3]` selects a set (set 0 = lines 0–1, set 1 = lines 2–3) and `addr[7:4]` is compared. A miss fills way 0, then way 1, then evicts the way of that set filled earlier. Each set keeps its own order.
- R5: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in `S_IDLE` when no flush or mode change is pending.
- R6: On a hit, `rsp_valid` and `rsp_hit` are 1 in the cycle that follows the accepting edge, with the requested byte on `rsp_data`.
- R7: On a miss, `req_ready` stays 0 while the block is copied. `rsp_valid` with `rsp_hit` = 0 appears after the eighth clock edge following the accepting edge. All eight bytes of the block are then resident and hit.
- R8: `stat_access` and `stat_hit` increment on the accepting edge and count at least 1023 accesses without wrapping. `stat_hit` never exceeds `stat_access`.
- R9: `stat_time` grows by 5 for a hit and by 30 (5 + 25) for a miss.
- R10: Asserting `flush`, or changing `mode_sel`, invalidates all lines, resets the replacement order and zeroes all three statistics in one edge. An unfinished fill is abandoned without a response.
- R11: The returned byte always equals the backing-store byte at the requested address. `mem_we` writes `mem_wdata` to `mem_waddr` on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mapping mode (0 direct, 1 fully associative, 2 two-way, 3 acts as direct) |
| flush | input | 1 | Synchronous clear of lines, replacement order and statistics |
| mem_we | input | 1 | Backing-store write strobe |
| mem_waddr | input | 8 | Backing-store write address |
| mem_wdata | input | 8 | Backing-store write byte |
| req_valid | input | 1 | Read request present |
| req_addr | input | 8 | Read byte address |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was served from a resident line |
| rsp_data | output | 8 | Returned byte |
| stat_access | output | 10 | Accesses since the last clear |
| stat_hit | output | 10 | Hits since the last clear |
| stat_time | output | 15 | Accumulated access-time units |

## Verification
The hardest condition to reach from the ports is a replacement decision that separates first-in-first-out from recency order. The stimulus reaches it by filling every candidate line, then hitting the oldest line repeatedly, and only then missing on a new block. A FIFO policy evicts the re-used block, so an immediate re-read of that block must miss. The same pattern is applied to one set in two-way mode while the other set is shown to keep its contents. The 1023-access counter limit is reached by one miss followed by a long run of hits to the same block.

// File: rtl/tricache_pkg.sv
package tricache_pkg;

    typedef enum logic [1:0] {
        MAP_DIRECT = 2'd0,
        MAP_FULL   = 2'd1,
        MAP_TWOWAY = 2'd2,
        MAP_RSVD   = 2'd3
    } map_mode_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_FILL = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/tricache_backing.sv
module tricache_backing #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    // fill port and response port read independently
    assign rd_a_data = store_q[rd_a_addr];
    assign rd_b_data = store_q[rd_b_addr];
endmodule

// File: rtl/tricache_tags.sv
module tricache_tags
    import tricache_pkg::*;
#(
    parameter int LINES = 4,
    parameter int WAYS  = 2,
    parameter int BLK_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  map_mode_e                mode,
    input  logic [BLK_W-1:0]         look_blk,
    output logic                     look_hit,
    output logic [$clog2(LINES)-1:0] look_line,
    output logic [$clog2(LINES)-1:0] look_victim,
    input  logic                     inst_en,
    input  logic [$clog2(LINES)-1:0] inst_line,
    input  logic [BLK_W-1:0]         inst_blk
);
    localparam int LINE_W = $clog2(LINES);
    localparam int SETS   = LINES / WAYS;
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [LINES-1:0] valid_q;
    logic [BLK_W-1:0] tag_q [LINES];
    logic [LINE_W-1:0] fa_ptr_q;
    logic [WAY_W-1:0]  way_ptr_q [SETS];

    logic [LINES-1:0] cand;
    logic [LINES-1:0] match;
    logic [SET_W-1:0] look_set;
    logic [SET_W-1:0] inst_set;

    assign look_set = look_blk[SET_W-1:0];
    assign inst_set = SET_W'(inst_line >> WAY_W);

    // which lines may hold the looked-up block in the current mode
    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            unique case (mode)
                MAP_FULL:   cand[l] = 1'b1;
                MAP_TWOWAY: cand[l] = ((l / WAYS) == int'(look_set));
                default:    cand[l] = (l == int'(look_blk[LINE_W-1:0]));
            endcase
        end
    end

    // full block number is stored, so one comparator serves every mode
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_cmp
            assign match[g] = cand[g] & valid_q[g] & (tag_q[g] == look_blk);
        end
    endgenerate

    always_comb begin
        look_line = '0;
        for (int l = LINES - 1; l >= 0; l--) begin
            if (match[l]) look_line = LINE_W'(l);
        end
    end
    assign look_hit = |match;

    always_comb begin
        look_victim = '0;
        unique case (mode)
            MAP_FULL: begin
                look_victim = fa_ptr_q;
                for (int l = LINES - 1; l >= 0; l--) begin
                    if (!valid_q[l]) look_victim = LINE_W'(l);
                end
            end
            MAP_TWOWAY: begin
                look_victim = LINE_W'(int'(look_set) * WAYS + int'(way_ptr_q[look_set]));
                for (int w = WAYS - 1; w >= 0; w--) begin
                    if (!valid_q[int'(look_set) * WAYS + w]) begin
                        look_victim = LINE_W'(int'(look_set) * WAYS + w);
                    end
                end
            end
            default: look_victim = look_blk[LINE_W-1:0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= '0;
            fa_ptr_q <= '0;
            for (int s = 0; s < SETS; s++) way_ptr_q[s] <= '0;
        end else if (clear) begin
            valid_q  <= '0;
            fa_ptr_q <= '0;
            for (int s = 0; s < SETS; s++) way_ptr_q[s] <= '0;
        end else if (inst_en) begin
            valid_q[inst_line] <= 1'b1;
            // overwriting a valid line means the oldest entry left
            if (valid_q[inst_line]) begin
                if (mode == MAP_FULL) begin
                    fa_ptr_q <= fa_ptr_q + 1'b1;
                end else if (mode == MAP_TWOWAY) begin
                    way_ptr_q[inst_set] <= way_ptr_q[inst_set] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en && !clear) begin
            tag_q[inst_line] <= inst_blk;
        end
    end
endmodule

// File: rtl/tricache_lines.sv
module tricache_lines #(
    parameter int LINES      = 4,
    parameter int LINE_BYTES = 8,
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(LINES)-1:0]      wr_line,
    input  logic [$clog2(LINE_BYTES)-1:0] wr_off,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(LINES)-1:0]      rd_line,
    input  logic [$clog2(LINE_BYTES)-1:0] rd_off,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int BYTES = LINES * LINE_BYTES;

    logic [DATA_W-1:0] data_q [BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[{wr_line, wr_off}] <= wr_data;
        end
    end

    assign rd_data = data_q[{rd_line, rd_off}];
endmodule

// File: rtl/tricache_stats.sv
module tricache_stats #(
    parameter int CNT_W     = 10,
    parameter int TIME_W    = 15,
    parameter int HIT_COST  = 5,
    parameter int MISS_COST = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bump,
    input  logic              bump_hit,
    output logic [CNT_W-1:0]  acc_q,
    output logic [CNT_W-1:0]  hit_q,
    output logic [TIME_W-1:0] time_q
);
    localparam logic [TIME_W-1:0] STEP_HIT  = TIME_W'(HIT_COST);
    localparam logic [TIME_W-1:0] STEP_MISS = TIME_W'(HIT_COST + MISS_COST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            hit_q  <= '0;
            time_q <= '0;
        end else if (clear) begin
            acc_q  <= '0;
            hit_q  <= '0;
            time_q <= '0;
        end else if (bump) begin
            acc_q <= acc_q + 1'b1;
            if (bump_hit) begin
                hit_q  <= hit_q + 1'b1;
                time_q <= time_q + STEP_HIT;
            end else begin
                time_q <= time_q + STEP_MISS;
            end
        end
    end
endmodule

// File: rtl/tricache_ctrl.sv
module tricache_ctrl
    import tricache_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int LINES      = 4,
    parameter int LINE_BYTES = 8,
    parameter int WAYS       = 2,
    parameter int CNT_W      = 10,
    parameter int TIME_W     = 15,
    parameter int HIT_COST   = 5,
    parameter int MISS_COST  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              flush,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  stat_access,
    output logic [CNT_W-1:0]  stat_hit,
    output logic [TIME_W-1:0] stat_time
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int LINE_W = $clog2(LINES);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(LINE_BYTES - 1);

    ctl_state_e state_q, state_d;
    map_mode_e  mode_q;

    logic              clear;
    logic              accept;
    logic              fill_wr;
    logic              inst_en;
    logic [OFF_W-1:0]  fill_cnt_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [LINE_W-1:0] victim_q;
    logic [BLK_W-1:0]  blk_q;

    logic              look_hit;
    logic [LINE_W-1:0] look_line;
    logic [LINE_W-1:0] look_victim;
    logic [DATA_W-1:0] line_rd;
    logic [DATA_W-1:0] fill_byte;
    logic [DATA_W-1:0] miss_byte;

    assign clear  = flush | (mode_sel != mode_q);
    assign accept = req_valid & req_ready;
    assign blk_q  = req_addr_q[ADDR_W-1:OFF_W];

    tricache_backing #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_backing (
        .clk       (clk),
        .wr_en     (mem_we),
        .wr_addr   (mem_waddr),
        .wr_data   (mem_wdata),
        .rd_a_addr ({blk_q, fill_cnt_q}),
        .rd_a_data (fill_byte),
        .rd_b_addr (req_addr_q),
        .rd_b_data (miss_byte)
    );

    tricache_tags #(.LINES(LINES), .WAYS(WAYS), .BLK_W(BLK_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .mode        (mode_q),
        .look_blk    (req_addr[ADDR_W-1:OFF_W]),
        .look_hit    (look_hit),
        .look_line   (look_line),
        .look_victim (look_victim),
        .inst_en     (inst_en),
        .inst_line   (victim_q),
        .inst_blk    (blk_q)
    );

    tricache_lines #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u_lines (
        .clk     (clk),
        .wr_en   (fill_wr),
        .wr_line (victim_q),
        .wr_off  (fill_cnt_q),
        .wr_data (fill_byte),
        .rd_line (look_line),
        .rd_off  (req_addr[OFF_W-1:0]),
        .rd_data (line_rd)
    );

    tricache_stats #(
        .CNT_W(CNT_W), .TIME_W(TIME_W), .HIT_COST(HIT_COST), .MISS_COST(MISS_COST)
    ) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .bump     (accept),
        .bump_hit (look_hit),
        .acc_q    (stat_access),
        .hit_q    (stat_hit),
        .time_q   (stat_time)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-state controls
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        fill_wr   = 1'b0;
        inst_en   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = !clear;
                if (req_valid && !clear && !look_hit) state_d = S_FILL;
            end
            S_FILL: begin
                if (clear) begin
                    state_d = S_IDLE;
                end else begin
                    fill_wr = 1'b1;
                    if (fill_cnt_q == OFF_LAST) begin
                        inst_en = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MAP_DIRECT;
            fill_cnt_q <= '0;
            req_addr_q <= '0;
            victim_q   <= '0;
        end else begin
            mode_q <= map_mode_e'(mode_sel);
            if (accept) begin
                fill_cnt_q <= '0;
                req_addr_q <= req_addr;
                victim_q   <= look_victim;
            end else if (fill_wr) begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && look_hit) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b1;
                rsp_data  <= line_rd;
            end else if (inst_en) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b0;
                rsp_data  <= miss_byte;
            end
        end
    end
endmodule

// File: rtl/tricache_ctrl_chk.sv
module tricache_ctrl_chk
    import tricache_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int TIME_W     = 15,
    parameter int LINE_BYTES = 8,
    parameter int HIT_COST   = 5,
    parameter int MISS_COST  = 25
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          flush,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          rsp_valid,
    input logic                          rsp_hit,
    input logic [CNT_W-1:0]              stat_access,
    input logic [CNT_W-1:0]              stat_hit,
    input logic [TIME_W-1:0]             stat_time,
    input ctl_state_e                    state_q,
    input logic [$clog2(LINE_BYTES)-1:0] fill_cnt_q
);
    localparam logic [$clog2(LINE_BYTES)-1:0] CNT_LAST = '1;

    assert_hit_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));

    assert_busy_in_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL) |-> !req_ready);

    assert_miss_after_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> ($past(state_q) == S_FILL && $past(fill_cnt_q) == CNT_LAST));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit <= stat_access);

    assert_time_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stat_time) == HIT_COST * int'(stat_access)
                           + MISS_COST * (int'(stat_access) - int'(stat_hit)));

    assert_flush_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (stat_access == '0 && stat_hit == '0 && stat_time == '0 && !rsp_valid));
endmodule

bind tricache_ctrl tricache_ctrl_chk #(
    .CNT_W(CNT_W), .TIME_W(TIME_W), .LINE_BYTES(LINE_BYTES),
    .HIT_COST(HIT_COST), .MISS_COST(MISS_COST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .stat_access (stat_access),
    .stat_hit    (stat_hit),
    .stat_time   (stat_time),
    .state_q     (state_q),
    .fill_cnt_q  (fill_cnt_q)
);

// File: tb/test_tricache_ctrl.sv
`timescale 1ns/1ps
module test_tricache_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       flush = 1'b0;
    logic       mem_we = 1'b0;
    logic [7:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic       req_ready, rsp_valid, rsp_hit;
    logic [7:0] rsp_data;
    logic [9:0] stat_access, stat_hit;
    logic [14:0] stat_time;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int m_acc = 0, m_hit = 0, m_time = 0;
    logic [7:0] exp_mem [256];

    always #2.5 clk = ~clk;

    tricache_ctrl i_tricache_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .flush(flush),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .stat_access(stat_access), .stat_hit(stat_hit), .stat_time(stat_time)
    );

    // {clear-first, mode[1:0], expect-hit, addr[7:0]}
    localparam logic [11:0] VEC [42] = '{
        12'h82C, 12'h06D, 12'h086, 12'h029, 12'h0A5, 12'h082, 12'h0A7, 12'h068,
        12'h080, 12'h02B, 12'h12F, 12'h181,
        12'hA2C, 12'h26D, 12'h286, 12'h329, 12'h2A5, 12'h382, 12'h3A7, 12'h368,
        12'h380, 12'h32B, 12'h200, 12'h22B, 12'h26D, 12'h286, 12'h300,
        12'hC2C, 12'h46D, 12'h486, 12'h529, 12'h4A5, 12'h582, 12'h5A7, 12'h568,
        12'h580, 12'h52B, 12'h4C0, 12'h480, 12'h4A0, 12'h584, 12'h52A
    };

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_stats(input string rq);
        chk(int'(stat_access) == m_acc, "R8", {rq, " access count"}, int'(stat_access), m_acc);
        chk(int'(stat_hit) == m_hit, "R8", {rq, " hit count"}, int'(stat_hit), m_hit);
        chk(int'(stat_time) == m_time, "R9", {rq, " time total"}, int'(stat_time), m_time);
    endtask

    task automatic do_access(input logic [7:0] a, input bit exp_hit, input string rq);
        int n;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        chk(req_ready === 1'b1, "R5", "ready in idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        if (!exp_hit) chk(req_ready === 1'b0, "R7", "ready during copy", int'(req_ready), 0);
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        m_acc++;
        if (exp_hit) begin
            m_hit++;
            m_time += 5;
        end else begin
            m_time += 30;
        end
        chk(rsp_hit === exp_hit, rq, $sformatf("hit flag at 0x%02h", a), int'(rsp_hit), int'(exp_hit));
        chk(n == (exp_hit ? 1 : 9), exp_hit ? "R6" : "R7", "response latency", n, exp_hit ? 1 : 9);
        chk(rsp_data === exp_mem[a], "R11", $sformatf("data at 0x%02h", a), int'(rsp_data), int'(exp_mem[a]));
        chk_stats(rq);
    endtask

    task automatic restart(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        flush    = 1'b1;
        #1;
        chk(req_ready === 1'b0, "R5", "ready while clearing", int'(req_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        m_acc = 0; m_hit = 0; m_time = 0;
        chk_stats("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'(a * 7) ^ 8'h3C;
        // preload while reset is held
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            mem_we = 1'b1; mem_waddr = 8'(a); mem_wdata = exp_mem[a];
        end
        @(negedge clk);
        mem_we = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(rsp_valid === 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
        chk_stats("R1");
        do_access(8'h00, 1'b0, "R1");

        // table of three mapping scenarios
        for (int i = 0; i < 42; i++) begin
            logic [11:0] v;
            string rq;
            v = VEC[i];
            if (v[11]) restart(v[10:9]);
            rq = (v[10:9] == 2'd0) ? "R2" : (v[10:9] == 2'd1) ? "R3" : "R4";
            do_access(v[7:0], v[8], rq);
        end

        // R10 flush drops resident block
        restart(2'd2);
        do_access(8'h2A, 1'b0, "R10");
        do_access(8'h2A, 1'b1, "R10");

        // R10 mode change alone also clears
        @(negedge clk);
        mode_sel = 2'd1;
        #1;
        chk(req_ready === 1'b0, "R10", "ready on mode change", int'(req_ready), 0);
        @(negedge clk);
        m_acc = 0; m_hit = 0; m_time = 0;
        chk_stats("R10");
        do_access(8'h2A, 1'b0, "R10");

        // R11 backing write then read of a fresh block
        @(negedge clk);
        mem_we = 1'b1; mem_waddr = 8'h91; mem_wdata = 8'hA5;
        exp_mem[8'h91] = 8'hA5;
        @(negedge clk);
        mem_we = 1'b0;
        do_access(8'h91, 1'b0, "R11");

        // R7 every byte of a filled block is resident
        restart(2'd1);
        do_access(8'h43, 1'b0, "R7");
        for (int b = 0; b < 8; b++) do_access(8'h40 + 8'(b), 1'b1, "R7");

        // R8 reach 1023 accesses without wrap
        restart(2'd0);
        do_access(8'h58, 1'b0, "R8");
        for (int k = 0; k < 1022; k++) do_access(8'h5B, 1'b1, "R8");
        chk(int'(stat_access) == 1023, "R8", "final access count", int'(stat_access), 1023);
        chk(int'(stat_time) == 5140, "R9", "final time total", int'(stat_time), 5140);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule